// File: doc/BRIEF.md
# Flash Byte Programming Controller

This block lets software running on the chip read, erase or program one byte at a time in a few reserved windows of the on-chip flash. Software sets a 6-bit offset and, for a program, a data byte, through small special-function registers. It then writes a control register that names a window and an operation. If the configuration straps allow the write, the block halts the CPU, drives a byte-wide flash port for a fixed number of cycles and, for a read, stores the fetched byte in its data register. When the operation ends, the control register returns to zero and the CPU continues.

Erase and program are slow. Before either one starts, the block sends a one-cycle clear to the watchdog, and it holds the strobe for a programmable cycle count that stands in for about two milliseconds. Every attempt to write the control register also pulses a watchdog-enable request, whether or not the write is taken. The small information window can only be read.

Top module: `iap_ctrl`

## Requirements
- R1: Register select 0 is the control register, 1 the offset register, 2 the data register, and 3 reads zero. The control register holds the window in bits [3:2] and the operation in bits [1:0], and bits [7:4] read zero. The offset register reads its 6 bits with bits [7:6] as zero.
- R2: The flash address is 0x1C0 plus the offset for window 0, 0x3C0 plus the offset for window 1, and offset bits [2:0] alone for window 2 (the information window). The address holds steady while the CPU is stalled.
- R3: Operation code 0 (none) and window code 3 (reserved) start no cycle, do not stall the CPU and leave the control register reading zero.
- R4: A control write is taken only when map bit 0 is low, map bit 1 is high, and the enable bit for the chosen window is high. Bit 0 enables window 0 and bit 1 enables window 1; window 2 needs no enable bit. A write that is not taken changes no state.
- R5: Erase (code 1) and program (code 2) aimed at window 2 start nothing and leave the flash unchanged. Read (code 3) there is allowed.
- R6: A read drives the read strobe for exactly 6 cycles. The byte at the addressed location then appears in the data register.
- R7: Erase or program holds its strobe for PRG_CYCLES cycles. Erase leaves 0xFF and program leaves the data register value at the addressed location. Only one flash or watchdog strobe is active at a time.
- R8: The CPU stall rises in the cycle after an accepted write. It lasts 6 cycles for a read and PRG_CYCLES+1 cycles for erase or program. The control register reads zero once the stall ends.
- R9: Each control write made while the CPU is not stalled gives a one-cycle watchdog-enable pulse in the next cycle. Erase and program first give a one-cycle watchdog clear, which is followed directly by the flash strobe.
- R10: Register writes that arrive while the CPU is stalled are ignored. They change no register, start no operation and give no watchdog pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_we | input | 1 | Register write strobe |
| sfr_sel | input | 2 | Register select (0 control, 1 offset, 2 data) |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Read data of the selected register |
| map_b0 | input | 1 | Map strap bit 0 (must be low) |
| map_b1 | input | 1 | Map strap bit 1 (must be high) |
| region_cfg | input | 2 | Per-window enable bits for windows 0 and 1 |
| cpu_stall | output | 1 | Halts the CPU while an operation runs |
| wdt_en_set | output | 1 | One-cycle watchdog enable request |
| wdt_clear | output | 1 | One-cycle watchdog clear before erase or program |
| flash_addr | output | 10 | Flash byte address |
| flash_wdata | output | 8 | Flash program data |
| flash_rdata | input | 8 | Flash read data |
| flash_rd | output | 1 | Read strobe |
| flash_erase | output | 1 | Erase strobe |
| flash_prog | output | 1 | Program strobe |

## Verification
The hardest case to reach is a register write that arrives while an operation is already running. A real CPU cannot issue one, because it is halted. The bench drives the register port directly during an erase: it writes the data register, the offset register and a new control value. It then reads back the registers after the stall drops, checks that no watchdog pulse and no second operation came from those writes, and checks that the erase landed where it should. A sweep over every window, every operation and all eight strap combinations covers each branch of the gating.

// File: rtl/iap_pkg.sv
package iap_pkg;

    // register select codes
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_OFFS = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;

    // window codes
    localparam logic [1:0] WIN_0    = 2'd0;
    localparam logic [1:0] WIN_1    = 2'd1;
    localparam logic [1:0] WIN_INFO = 2'd2;
    localparam logic [1:0] WIN_RSVD = 2'd3;

    // operation codes
    localparam logic [1:0] OP_NONE  = 2'd0;
    localparam logic [1:0] OP_ERASE = 2'd1;
    localparam logic [1:0] OP_PROG  = 2'd2;
    localparam logic [1:0] OP_READ  = 2'd3;

    typedef struct packed {
        logic [1:0] win;
        logic [1:0] op;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WDCLR = 2'd2,
        ST_PROG  = 2'd3
    } state_e;

endpackage

// File: rtl/iap_gate.sv
module iap_gate
    import iap_pkg::*;
#(
    parameter int N_CFG = 2
) (
    input  logic [1:0]       win,
    input  logic [1:0]       op,
    input  logic             map_b0,
    input  logic             map_b1,
    input  logic [N_CFG-1:0] region_cfg,
    output logic             allow,
    output logic             launch
);

    logic win_ok;
    logic info_write;

    always_comb begin
        win_ok = 1'b0;
        if (win == WIN_INFO) begin
            win_ok = 1'b1;
        end else if (int'(win) < N_CFG) begin
            win_ok = region_cfg[win[$clog2(N_CFG)-1:0]];
        end
    end

    assign info_write = (win == WIN_INFO) && ((op == OP_ERASE) || (op == OP_PROG));
    assign allow      = !map_b0 && map_b1 && win_ok && (win != WIN_RSVD);
    assign launch     = allow && (op != OP_NONE) && !info_write;

endmodule

// File: rtl/iap_timer.sv
module iap_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/iap_ctrl.sv
module iap_ctrl
    import iap_pkg::*;
#(
    parameter int              ADDR_W     = 10,
    parameter int              DATA_W     = 8,
    parameter int              LOW_W      = 6,
    parameter int              INFO_W     = 3,
    parameter int              RD_CYCLES  = 6,
    parameter int              PRG_CYCLES = 24000,
    parameter logic [ADDR_W-1:0] WIN0_BASE = 10'h1C0,
    parameter logic [ADDR_W-1:0] WIN1_BASE = 10'h3C0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfr_we,
    input  logic [1:0]        sfr_sel,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] sfr_rdata,
    input  logic              map_b0,
    input  logic              map_b1,
    input  logic [1:0]        region_cfg,
    output logic              cpu_stall,
    output logic              wdt_en_set,
    output logic              wdt_clear,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [DATA_W-1:0] flash_wdata,
    input  logic [DATA_W-1:0] flash_rdata,
    output logic              flash_rd,
    output logic              flash_erase,
    output logic              flash_prog
);

    localparam int CNT_MAX = (PRG_CYCLES > RD_CYCLES) ? PRG_CYCLES : RD_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX) + 1;
    localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYCLES - 1);
    localparam logic [CNT_W-1:0] PRG_LOAD = CNT_W'(PRG_CYCLES - 1);
    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        state_e            st;
        ctrl_t             ctrl;
        logic [LOW_W-1:0]  offs;
        logic [DATA_W-1:0] data;
        logic              wdt_en;
    } regs_t;

    regs_t q, d;

    logic             gate_allow;
    logic             gate_launch;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_dec;
    logic             tmr_zero;
    logic [CTRL_W-1:0] ctrl_cur;

    ctrl_t req;
    assign req = ctrl_t'(sfr_wdata[CTRL_W-1:0]);

    iap_gate #(.N_CFG(2)) u_gate (
        .win        (req.win),
        .op         (req.op),
        .map_b0     (map_b0),
        .map_b1     (map_b1),
        .region_cfg (region_cfg),
        .allow      (gate_allow),
        .launch     (gate_launch)
    );

    iap_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    // next-state logic
    always_comb begin
        d        = q;
        d.wdt_en = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_dec  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (sfr_we) begin
                    case (sfr_sel)
                        SEL_CTRL: begin
                            d.wdt_en = 1'b1;
                            if (gate_launch) begin
                                d.ctrl = req;
                                if (req.op == OP_READ) begin
                                    d.st     = ST_READ;
                                    tmr_load = 1'b1;
                                    tmr_val  = RD_LOAD;
                                end else begin
                                    d.st = ST_WDCLR;
                                end
                            end
                        end
                        SEL_OFFS: d.offs = sfr_wdata[LOW_W-1:0];
                        SEL_DATA: d.data = sfr_wdata;
                        default: ;
                    endcase
                end
            end
            ST_READ: begin
                if (tmr_zero) begin
                    d.data = flash_rdata;
                    d.ctrl = '0;
                    d.st   = ST_IDLE;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_WDCLR: begin
                tmr_load = 1'b1;
                tmr_val  = PRG_LOAD;
                d.st     = ST_PROG;
            end
            ST_PROG: begin
                if (tmr_zero) begin
                    d.ctrl = '0;
                    d.st   = ST_IDLE;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // address composition from the latched window and offset
    always_comb begin
        case (q.ctrl.win)
            WIN_0:    flash_addr = WIN0_BASE + ADDR_W'(q.offs);
            WIN_1:    flash_addr = WIN1_BASE + ADDR_W'(q.offs);
            WIN_INFO: flash_addr = ADDR_W'(q.offs[INFO_W-1:0]);
            default:  flash_addr = '0;
        endcase
    end

    assign ctrl_cur = q.ctrl;

    always_comb begin
        case (sfr_sel)
            SEL_CTRL: sfr_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_cur};
            SEL_OFFS: sfr_rdata = {{(DATA_W-LOW_W){1'b0}}, q.offs};
            SEL_DATA: sfr_rdata = q.data;
            default:  sfr_rdata = '0;
        endcase
    end

    assign cpu_stall   = (q.st != ST_IDLE);
    assign wdt_en_set  = q.wdt_en;
    assign wdt_clear   = (q.st == ST_WDCLR);
    assign flash_rd    = (q.st == ST_READ);
    assign flash_erase = (q.st == ST_PROG) && (q.ctrl.op == OP_ERASE);
    assign flash_prog  = (q.st == ST_PROG) && (q.ctrl.op == OP_PROG);
    assign flash_wdata = q.data;

endmodule

// File: rtl/iap_ctrl_chk.sv
module iap_ctrl_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sfr_we,
    input logic [1:0]        sfr_sel,
    input logic              cpu_stall,
    input logic              wdt_en_set,
    input logic              wdt_clear,
    input logic              flash_rd,
    input logic              flash_erase,
    input logic              flash_prog,
    input logic [ADDR_W-1:0] flash_addr,
    input logic [3:0]        ctrl_cur
);

    p_strobe_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flash_rd, flash_erase, flash_prog, wdt_clear}));

    p_strobe_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_rd || flash_erase || flash_prog || wdt_clear) |-> cpu_stall);

    p_clear_then_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clear |=> (flash_erase || flash_prog));

    p_strobe_after_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_erase || flash_prog) |-> $past(wdt_clear));

    p_ctrl_self_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_stall) |-> (ctrl_cur == 4'd0));

    p_wdt_en_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_we && sfr_sel == 2'd0 && !cpu_stall) |=> wdt_en_set);

    p_info_read_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_erase || flash_prog) |-> (ctrl_cur[3:2] != 2'd2));

    p_addr_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stall && $past(cpu_stall)) |-> $stable(flash_addr));

endmodule

bind iap_ctrl iap_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sfr_we      (sfr_we),
    .sfr_sel     (sfr_sel),
    .cpu_stall   (cpu_stall),
    .wdt_en_set  (wdt_en_set),
    .wdt_clear   (wdt_clear),
    .flash_rd    (flash_rd),
    .flash_erase (flash_erase),
    .flash_prog  (flash_prog),
    .flash_addr  (flash_addr),
    .ctrl_cur    (ctrl_cur)
);

// File: tb/tb_iap_ctrl.sv
module tb_iap_ctrl;

    localparam int PRG = 20;
    localparam int RD  = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sfr_we;
    logic [1:0] sfr_sel;
    logic [7:0] sfr_wdata;
    logic [7:0] sfr_rdata;
    logic       map_b0, map_b1;
    logic [1:0] region_cfg;
    logic       cpu_stall, wdt_en_set, wdt_clear;
    logic [9:0] flash_addr;
    logic [7:0] flash_wdata, flash_rdata;
    logic       flash_rd, flash_erase, flash_prog;

    always #5 clk = ~clk;

    iap_ctrl #(.PRG_CYCLES(PRG)) dut (
        .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_sel(sfr_sel),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .map_b0(map_b0),
        .map_b1(map_b1), .region_cfg(region_cfg), .cpu_stall(cpu_stall),
        .wdt_en_set(wdt_en_set), .wdt_clear(wdt_clear), .flash_addr(flash_addr),
        .flash_wdata(flash_wdata), .flash_rdata(flash_rdata), .flash_rd(flash_rd),
        .flash_erase(flash_erase), .flash_prog(flash_prog)
    );

    // flash model
    logic [7:0] mem [0:1023];
    assign flash_rdata = mem[flash_addr];
    always @(posedge clk) begin
        if (flash_prog)       mem[flash_addr] <= flash_wdata;
        else if (flash_erase) mem[flash_addr] <= 8'hFF;
    end

    int errs   = 0;
    int checks = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    task automatic sfr_wr(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        sfr_we = 1'b1; sfr_sel = s; sfr_wdata = v;
        @(negedge clk);
        sfr_we = 1'b0;
    endtask

    task automatic sfr_rd(input logic [1:0] s, output logic [7:0] v);
        sfr_sel = s;
        #1;
        v = sfr_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        logic [7:0] rv;
        int trial;
        trial = 0;
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
        rst_n = 1'b0; sfr_we = 1'b0; sfr_sel = 2'd0; sfr_wdata = 8'd0;
        map_b0 = 1'b0; map_b1 = 1'b0; region_cfg = 2'b00;
        repeat (3) @(negedge clk);
        chk("R8", "stall in reset", int'(cpu_stall), 0);
        chk("R7", "strobes in reset", int'({flash_rd, flash_erase, flash_prog, wdt_clear}), 0);
        sfr_rd(2'd0, rv);
        chk("R1", "ctrl in reset", int'(rv), 0);
        rst_n = 1'b1;

        // R1 readback widths
        sfr_wr(2'd1, 8'hFF);
        sfr_rd(2'd1, rv);
        chk("R1", "offset readback", int'(rv), 8'h3F);
        sfr_wr(2'd2, 8'hA5);
        sfr_rd(2'd2, rv);
        chk("R1", "data readback", int'(rv), 8'hA5);
        sfr_rd(2'd3, rv);
        chk("R1", "unused select", int'(rv), 0);

        // sweep windows x operations x strap combinations
        for (int win = 0; win < 4; win++) begin
            for (int op = 0; op < 4; op++) begin
                for (int g = 0; g < 8; g++) begin
                    logic [5:0] lo;
                    logic [7:0] dv, old;
                    logic [9:0] ea;
                    bit allow, launch, isrd, ispe;
                    int n_st, n_rd, n_pe, n_clr, bad_addr, exp_st;
                    string tag;
                    trial++;
                    lo = 6'((trial * 13 + 5) & 63);
                    dv = 8'(trial * 29 + 17);
                    map_b0 = g[0];
                    map_b1 = g[1];
                    if (win == 0)      region_cfg = {~g[2], g[2]};
                    else if (win == 1) region_cfg = {g[2], ~g[2]};
                    else               region_cfg = {g[2], ~g[2]};
                    case (win)
                        0: ea = 10'h1C0 + 10'(lo);
                        1: ea = 10'h3C0 + 10'(lo);
                        2: ea = 10'(lo & 6'd7);
                        default: ea = 10'd0;
                    endcase
                    allow  = !map_b0 && map_b1 &&
                             ((win == 0) ? region_cfg[0] : (win == 1) ? region_cfg[1] : (win == 2));
                    launch = allow && (op != 0) && !(win == 2 && (op == 1 || op == 2));
                    isrd   = launch && (op == 3);
                    ispe   = launch && (op == 1 || op == 2);
                    if (!allow)                           tag = "R4";
                    else if (win == 2 && (op == 1 || op == 2)) tag = "R5";
                    else if (!launch)                     tag = "R3";
                    else                                  tag = "R7";

                    sfr_wr(2'd1, 8'(lo));
                    sfr_wr(2'd2, dv);
                    old = mem[ea];
                    sfr_wr(2'd0, 8'hF0 | 8'(win << 2) | 8'(op));
                    sfr_rd(2'd0, rv);
                    chk("R9", "wdt enable pulse", int'(wdt_en_set), 1);
                    chk(launch ? "R1" : tag, "ctrl during op", int'(rv), launch ? ((win << 2) | op) : 0);

                    n_st = 0; n_rd = 0; n_pe = 0; n_clr = 0; bad_addr = 0;
                    while (cpu_stall && n_st < 1000) begin
                        n_st++;
                        if (flash_rd) n_rd++;
                        if (flash_erase || flash_prog) n_pe++;
                        if (wdt_clear) n_clr++;
                        if ((flash_rd || flash_erase || flash_prog) && flash_addr != ea) bad_addr++;
                        @(negedge clk);
                        #1;
                    end
                    exp_st = isrd ? RD : (ispe ? PRG + 1 : 0);
                    chk(launch ? "R8" : tag, "stall cycles", n_st, exp_st);
                    chk("R6", "read strobe cycles", n_rd, isrd ? RD : 0);
                    chk("R7", "erase/program strobe cycles", n_pe, ispe ? PRG : 0);
                    chk("R9", "watchdog clear cycles", n_clr, ispe ? 1 : 0);
                    chk("R2", "address mismatches", bad_addr, 0);
                    chk(tag, "flash byte", int'(mem[ea]),
                        (launch && op == 1) ? 8'hFF : (launch && op == 2) ? int'(dv) : int'(old));
                    sfr_rd(2'd0, rv);
                    chk("R8", "ctrl after op", int'(rv), 0);
                    sfr_rd(2'd2, rv);
                    chk("R6", "data register", int'(rv), isrd ? int'(old) : int'(dv));
                end
            end
        end

        // R10: writes while stalled are ignored
        map_b0 = 1'b0; map_b1 = 1'b1; region_cfg = 2'b11;
        mem[10'h1C7] = 8'h12;
        sfr_wr(2'd1, 8'h07);
        sfr_wr(2'd2, 8'h33);
        sfr_wr(2'd0, 8'h01);
        sfr_we = 1'b1; sfr_sel = 2'd2; sfr_wdata = 8'hCC;
        @(negedge clk);
        sfr_sel = 2'd1; sfr_wdata = 8'h3F;
        @(negedge clk);
        sfr_sel = 2'd0; sfr_wdata = 8'h07;
        @(negedge clk);
        sfr_we = 1'b0;
        #1;
        chk("R10", "no wdt pulse from busy write", int'(wdt_en_set), 0);
        for (int k = 0; k < 1000 && cpu_stall; k++) @(negedge clk);
        repeat (3) begin
            @(negedge clk);
            #1;
            chk("R10", "no new operation", int'(cpu_stall), 0);
        end
        sfr_rd(2'd2, rv);
        chk("R10", "data unchanged", int'(rv), 8'h33);
        sfr_rd(2'd1, rv);
        chk("R10", "offset unchanged", int'(rv), 8'h07);
        chk("R7", "erase landed", int'(mem[10'h1C7]), 8'hFF);

        report();
    end

endmodule